// File: doc/BRIEF.md
# E3 Receive Frame Aligner

This block locates the frame boundary in a serial E3 receive bit stream. Bits arrive one per clock cycle in which the bit-valid enable is high. Idle cycles, with the enable low, carry no data. A format-select input chooses one of two framings:

- a 1536-bit frame that opens with a 10-bit alignment word;
- a 4296-bit (537-byte) frame that opens with a two-byte alignment sequence.

The aligner first hunts bit by bit for the alignment pattern. It then confirms the pattern at the expected frame spacing before it declares lock. While locked, it drops lock after a run of corrupted frames.

Downstream overhead and payload logic use four outputs:

- the in-frame flag and its complement, the out-of-frame flag;
- a one-cycle frame-start pulse on the first bit after each alignment pattern;
- a bit-position count within the frame.

Top module: `e3_frame_aligner`

## Requirements
- R1: After reset, `in_frame` is 0, `oof` is 1, `frame_start` is 0 and `bit_pos` is 0.
- R2: `fmt_sel` = 0 selects the 1536-bit frame whose alignment word is 1111010000. `fmt_sel` = 1 selects the 4296-bit frame whose alignment pattern is 16'hF628. In both formats the pattern is received leftmost bit first. Bits presented while `bit_en` is 0 are ignored.
- R3: With `fmt_sel` = 1, `in_frame` rises in the cycle after the last bit of the second of two alignment patterns whose ends are exactly 4296 bits apart.
- R4: With `fmt_sel` = 0, `in_frame` rises in the cycle after the last bit of the third alignment word in a row, each 1536 bits after the previous one. After only two such words it stays 0.
- R5: While confirming, a missing pattern at the expected position sends the aligner back to bit-by-bit hunting. The next pattern found then counts as the first of a new confirmation.
- R6: While in-frame, four consecutive frames with an invalid alignment pattern make `in_frame` fall and `oof` rise in the cycle after the fourth one.
- R7: While in-frame, one valid frame clears the count of invalid frames. Three invalid frames, then one valid frame, then three invalid frames leave `in_frame` at 1.
- R8: While in-frame, `frame_start` is a one-cycle pulse, with `bit_en` high, on the first bit after each alignment pattern. At that bit `bit_pos` equals the pattern length (10 or 16). There is exactly one pulse per frame.
- R9: `bit_pos` gives the in-frame index of the bit presented in the current cycle, where 0 is the first alignment bit. It wraps from period-1 to 0, and it holds its value while `bit_en` is 0.
- R10: A change of `fmt_sel` returns the aligner to hunting. In the next cycle `in_frame` is 0, `oof` is 1 and `bit_pos` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Serial receive data |
| fmt_sel | input | 1 | Frame format: 0 = 1536-bit frame, 1 = 4296-bit frame |
| in_frame | output | 1 | Frame alignment held |
| oof | output | 1 | Out of frame (hunting or confirming) |
| frame_start | output | 1 | First bit after the alignment pattern, in-frame only |
| bit_pos | output | 13 | In-frame index of the bit presented this cycle |

## Verification
The assertions assume the following about the inputs:

- `fmt_sel` only changes as a deliberate reconfiguration.
- A frame period is far longer than one cycle, so two frame-start pulses can never be adjacent.
- `bit_pos` can only move on an enabled bit or a format change.

The stimulus keeps within these assumptions:

- It changes `fmt_sel` only on idle cycles.
- It fills payload with zeros, so that no false alignment pattern can appear.
- It corrupts a frame only by inverting the first alignment bit.
- In the gap scenario, it drives ones on `bit_in` during disabled cycles to show that they are dropped.

// File: rtl/e3fa_pkg.sv
// Package e3fa_pkg
// Purpose : shared types and format constants for the E3 frame aligner.
// Assumes : nothing; pure declarations.
package e3fa_pkg;

    typedef enum logic {
        FMT_G751 = 1'b0,
        FMT_G832 = 1'b1
    } fmt_e;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } align_st_e;

    localparam int G751_FRAME_BITS = 1536;
    localparam int G832_FRAME_BITS = 4296;
    localparam int G751_FAW_LEN    = 10;
    localparam int G832_FAW_LEN    = 16;
    localparam logic [G751_FAW_LEN-1:0] G751_FAW = 10'b1111010000;
    localparam logic [G832_FAW_LEN-1:0] G832_FAW = 16'hF628;
    localparam int G751_CONFIRM    = 3;
    localparam int G832_CONFIRM    = 2;
    localparam int LOSS_FRAMES     = 4;

endpackage

// File: rtl/e3fa_faw_det.sv
// Module e3fa_faw_det
// Purpose : keeps a history of received bits and flags, in the same cycle as
//           the last pattern bit, that the alignment pattern of the selected
//           format has just completed.
// Assumes : bits arrive leftmost first, qualified by bit_en.
module e3fa_faw_det
    import e3fa_pkg::*;
#(
    parameter int                 LEN_751  = G751_FAW_LEN,
    parameter int                 LEN_832  = G832_FAW_LEN,
    parameter logic [LEN_751-1:0] WORD_751 = G751_FAW,
    parameter logic [LEN_832-1:0] WORD_832 = G832_FAW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    input  fmt_e fmt,
    output logic hit
);

    localparam int WIN_W  = (LEN_751 > LEN_832) ? LEN_751 : LEN_832;
    localparam int HIST_W = WIN_W - 1;

    logic [HIST_W-1:0] hist;
    logic [WIN_W-1:0]  win;
    logic              hit_751;
    logic              hit_832;

    // Current window: stored history followed by the bit on the line now.
    always_comb begin
        win = {hist, bit_in};
    end

    // Shift history on every qualified bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (bit_en) begin
            hist <= win[HIST_W-1:0];
        end
    end

    // Compare the window tail against each format's pattern.
    always_comb begin
        hit_751 = (win[LEN_751-1:0] == WORD_751);
        hit_832 = (win[LEN_832-1:0] == WORD_832);
        hit     = bit_en && ((fmt == FMT_G832) ? hit_832 : hit_751);
    end

endmodule

// File: rtl/e3fa_bit_pos.sv
// Module e3fa_bit_pos
// Purpose : in-frame bit index. Advances on each qualified bit, wraps at the
//           frame period, is loaded to the pattern length when a hunt hit
//           fixes the boundary, and is cleared on a format change.
// Assumes : load is only raised together with bit_en.
module e3fa_bit_pos
    import e3fa_pkg::*;
#(
    parameter int PER_751 = G751_FRAME_BITS,
    parameter int PER_832 = G832_FRAME_BITS,
    parameter int LEN_751 = G751_FAW_LEN,
    parameter int LEN_832 = G832_FAW_LEN,
    parameter int POS_W   = $clog2((PER_751 > PER_832) ? PER_751 : PER_832)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  fmt_e             fmt,
    input  logic             clr,
    input  logic             load,
    output logic [POS_W-1:0] pos,
    output logic             at_check,
    output logic             at_start
);

    localparam logic [POS_W-1:0] LAST_751  = POS_W'(PER_751 - 1);
    localparam logic [POS_W-1:0] LAST_832  = POS_W'(PER_832 - 1);
    localparam logic [POS_W-1:0] START_751 = POS_W'(LEN_751);
    localparam logic [POS_W-1:0] START_832 = POS_W'(LEN_832);
    localparam logic [POS_W-1:0] CHECK_751 = POS_W'(LEN_751 - 1);
    localparam logic [POS_W-1:0] CHECK_832 = POS_W'(LEN_832 - 1);

    logic [POS_W-1:0] last;
    logic [POS_W-1:0] start_idx;
    logic [POS_W-1:0] check_idx;

    // Pick the frame geometry of the selected format.
    always_comb begin
        if (fmt == FMT_G832) begin
            last      = LAST_832;
            start_idx = START_832;
            check_idx = CHECK_832;
        end else begin
            last      = LAST_751;
            start_idx = START_751;
            check_idx = CHECK_751;
        end
        at_check = (pos == check_idx);
        at_start = (pos == start_idx);
    end

    // Bit index register with load, wrap and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pos <= '0;
        end else if (bit_en) begin
            if (load) begin
                pos <= start_idx;
            end else if (pos == last) begin
                pos <= '0;
            end else begin
                pos <= pos + POS_W'(1);
            end
        end
    end

    // R9
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (pos <= last));

    // R9
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !clr) |=> $stable(pos));

endmodule

// File: rtl/e3fa_sync_fsm.sv
// Module e3fa_sync_fsm
// Purpose : hunt / confirm / locked control. Counts confirmed patterns at
//           the expected position until the format's confirm count is met,
//           and counts invalid frames while locked up to the loss limit.
// Assumes : hit and at_check are valid in the same cycle as the bit.
module e3fa_sync_fsm
    import e3fa_pkg::*;
#(
    parameter int CONF_751 = G751_CONFIRM,
    parameter int CONF_832 = G832_CONFIRM,
    parameter int LOSS     = LOSS_FRAMES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  fmt_e fmt,
    input  logic hit,
    input  logic at_check,
    output logic in_frame,
    output logic oof,
    output logic fmt_chg,
    output logic load
);

    localparam int CONF_MAX = (CONF_751 > CONF_832) ? CONF_751 : CONF_832;
    localparam int HIT_W    = $clog2(CONF_MAX + 1);
    localparam int MISS_W   = $clog2(LOSS + 1);

    align_st_e         state;
    fmt_e              fmt_q;
    logic [HIT_W-1:0]  hits;
    logic [MISS_W-1:0] miss;
    logic [HIT_W-1:0]  need;

    // Format-change detect, confirm target and boundary load strobe.
    always_comb begin
        fmt_chg  = (fmt != fmt_q);
        need     = (fmt == FMT_G832) ? HIT_W'(CONF_832) : HIT_W'(CONF_751);
        load     = (state == ST_HUNT) && !fmt_chg && bit_en && hit;
        in_frame = (state == ST_LOCKED);
        oof      = (state != ST_LOCKED);
    end

    // Alignment state, confirm count and invalid-frame count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            fmt_q <= FMT_G751;
            hits  <= '0;
            miss  <= '0;
        end else if (fmt_chg) begin
            state <= ST_HUNT;
            fmt_q <= fmt;
            hits  <= '0;
            miss  <= '0;
        end else if (bit_en) begin
            case (state)
                ST_HUNT: begin
                    if (hit) begin
                        state <= ST_CONFIRM;
                        hits  <= HIT_W'(1);
                    end
                end
                ST_CONFIRM: begin
                    if (at_check) begin
                        if (!hit) begin
                            state <= ST_HUNT;
                            hits  <= '0;
                        end else if ((hits + HIT_W'(1)) >= need) begin
                            state <= ST_LOCKED;
                            hits  <= '0;
                            miss  <= '0;
                        end else begin
                            hits <= hits + HIT_W'(1);
                        end
                    end
                end
                ST_LOCKED: begin
                    if (at_check) begin
                        if (hit) begin
                            miss <= '0;
                        end else if (miss == MISS_W'(LOSS - 1)) begin
                            state <= ST_HUNT;
                            miss  <= '0;
                        end else begin
                            miss <= miss + MISS_W'(1);
                        end
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // R3 R4
    lock_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> $past(bit_en && at_check && hit));

    // R6
    drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_frame) |-> $past(fmt_chg || (bit_en && at_check && !hit)));

    // R7
    miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame |-> (miss < MISS_W'(LOSS)));

    // R10
    fmt_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_chg |=> !in_frame);

endmodule

// File: rtl/e3_frame_aligner.sv
// Module e3_frame_aligner
// Purpose : top of the E3 receive frame aligner; joins the pattern detector,
//           the bit index counter and the alignment state machine and forms
//           the frame-start pulse.
// Assumes : one serial bit per cycle with bit_en high; fmt_sel quasi-static.
module e3_frame_aligner
    import e3fa_pkg::*;
#(
    parameter int                 PER_751  = G751_FRAME_BITS,
    parameter int                 PER_832  = G832_FRAME_BITS,
    parameter int                 LEN_751  = G751_FAW_LEN,
    parameter int                 LEN_832  = G832_FAW_LEN,
    parameter logic [LEN_751-1:0] WORD_751 = G751_FAW,
    parameter logic [LEN_832-1:0] WORD_832 = G832_FAW,
    parameter int                 CONF_751 = G751_CONFIRM,
    parameter int                 CONF_832 = G832_CONFIRM,
    parameter int                 LOSS     = LOSS_FRAMES,
    parameter int                 POS_W    = $clog2((PER_751 > PER_832) ? PER_751 : PER_832)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             fmt_sel,
    output logic             in_frame,
    output logic             oof,
    output logic             frame_start,
    output logic [POS_W-1:0] bit_pos
);

    fmt_e fmt;
    logic hit;
    logic at_check;
    logic at_start;
    logic fmt_chg;
    logic load;

    // Map the raw select pin onto the format type.
    always_comb begin
        fmt = fmt_e'(fmt_sel);
    end

    e3fa_faw_det #(
        .LEN_751  (LEN_751),
        .LEN_832  (LEN_832),
        .WORD_751 (WORD_751),
        .WORD_832 (WORD_832)
    ) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .bit_in (bit_in),
        .fmt    (fmt),
        .hit    (hit)
    );

    e3fa_bit_pos #(
        .PER_751 (PER_751),
        .PER_832 (PER_832),
        .LEN_751 (LEN_751),
        .LEN_832 (LEN_832),
        .POS_W   (POS_W)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .fmt      (fmt),
        .clr      (fmt_chg),
        .load     (load),
        .pos      (bit_pos),
        .at_check (at_check),
        .at_start (at_start)
    );

    e3fa_sync_fsm #(
        .CONF_751 (CONF_751),
        .CONF_832 (CONF_832),
        .LOSS     (LOSS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .fmt      (fmt),
        .hit      (hit),
        .at_check (at_check),
        .in_frame (in_frame),
        .oof      (oof),
        .fmt_chg  (fmt_chg),
        .load     (load)
    );

    // Frame-start strobe on the first bit after the pattern while locked.
    always_comb begin
        frame_start = in_frame && bit_en && at_start;
    end

    // R8
    fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R8
    fs_locked_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !oof || fmt_chg);

endmodule

// File: tb/test_e3_frame_aligner.sv
// Bench test_e3_frame_aligner
// Purpose : directed scenarios, one task each, every task checking itself.
module test_e3_frame_aligner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic        fmt_sel = 1'b0;
    logic        in_frame;
    logic        oof;
    logic        frame_start;
    logic [12:0] bit_pos;

    int checks = 0;
    int errors = 0;
    int fs_cnt = 0;
    int fs_pos = 0;
    int bit_idx = 0;
    bit gap_mode = 1'b0;
    bit done = 1'b0;

    localparam logic [9:0]  FAW_A = 10'b1111010000;
    localparam logic [15:0] FAW_B = 16'hF628;

    always #4 clk = ~clk;

    e3_frame_aligner i_e3_frame_aligner (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .bit_in      (bit_in),
        .fmt_sel     (fmt_sel),
        .in_frame    (in_frame),
        .oof         (oof),
        .frame_start (frame_start),
        .bit_pos     (bit_pos)
    );

    function automatic int period();
        return fmt_sel ? 4296 : 1536;
    endfunction

    function automatic int plen();
        return fmt_sel ? 16 : 10;
    endfunction

    function automatic bit word_bit(input int i);
        return fmt_sel ? FAW_B[15-i] : FAW_A[9-i];
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input bit b);
        bit_idx++;
        if (gap_mode && (bit_idx % 3 == 0)) begin
            @(negedge clk);
            bit_en = 1'b0;
            bit_in = 1'b1;
        end
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        #1;
        if (frame_start) begin
            fs_cnt++;
            fs_pos = int'(bit_pos);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bit_en = 1'b0;
            bit_in = 1'b0;
        end
    endtask

    task automatic send_frame(input bit good);
        for (int i = 0; i < plen(); i++) begin
            send_bit(word_bit(i) ^ (!good && i == 0));
        end
        for (int i = plen(); i < period(); i++) begin
            send_bit(1'b0);
        end
        idle(1);
    endtask

    task automatic lead_in();
        for (int i = 0; i < 37; i++) send_bit(1'b0);
    endtask

    task automatic do_reset(input bit f);
        rst_n = 1'b0;
        bit_en = 1'b0;
        bit_in = 1'b0;
        fmt_sel = f;
        gap_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        check("R1", "in_frame", int'(in_frame), 0);
        check("R1", "oof", int'(oof), 1);
        check("R1", "frame_start", int'(frame_start), 0);
        check("R1", "bit_pos", int'(bit_pos), 0);
    endtask

    task automatic t_751_acquire();
        do_reset(1'b0);
        lead_in();
        send_frame(1'b1);
        send_frame(1'b1);
        check("R4", "in_frame after two words", int'(in_frame), 0);
        send_frame(1'b1);
        check("R4", "in_frame after three words", int'(in_frame), 1);
        check("R2", "oof when locked", int'(oof), 0);
        check("R9", "bit_pos after full frame", int'(bit_pos), 0);
        fs_cnt = 0;
        send_frame(1'b1);
        check("R8", "frame_start pulses per frame", fs_cnt, 1);
        check("R8", "bit_pos at frame_start", fs_pos, 10);
    endtask

    task automatic t_751_loss();
        do_reset(1'b0);
        lead_in();
        repeat (3) send_frame(1'b1);
        repeat (3) send_frame(1'b0);
        check("R6", "in_frame after three bad", int'(in_frame), 1);
        send_frame(1'b1);
        repeat (3) send_frame(1'b0);
        check("R7", "in_frame after 3 bad, good, 3 bad", int'(in_frame), 1);
        send_frame(1'b0);
        check("R6", "in_frame after fourth bad", int'(in_frame), 0);
        check("R6", "oof after fourth bad", int'(oof), 1);
    endtask

    task automatic t_751_confirm_fail();
        do_reset(1'b0);
        lead_in();
        send_frame(1'b1);
        send_frame(1'b1);
        send_frame(1'b0);
        check("R5", "in_frame after miss in confirm", int'(in_frame), 0);
        send_frame(1'b1);
        send_frame(1'b1);
        check("R5", "no lock on two after restart", int'(in_frame), 0);
        send_frame(1'b1);
        check("R5", "lock on third after restart", int'(in_frame), 1);
    endtask

    task automatic t_fmt_change();
        do_reset(1'b0);
        lead_in();
        repeat (3) send_frame(1'b1);
        check("R10", "locked before change", int'(in_frame), 1);
        fmt_sel = 1'b1;
        @(negedge clk);
        check("R10", "in_frame after change", int'(in_frame), 0);
        check("R10", "oof after change", int'(oof), 1);
        check("R10", "bit_pos after change", int'(bit_pos), 0);
    endtask

    task automatic t_gaps();
        int held;
        do_reset(1'b0);
        gap_mode = 1'b1;
        lead_in();
        repeat (3) send_frame(1'b1);
        check("R9", "lock with idle gaps", int'(in_frame), 1);
        check("R9", "bit_pos wrap with gaps", int'(bit_pos), 0);
        for (int i = 0; i < 5; i++) send_bit(word_bit(i));
        idle(1);
        held = int'(bit_pos);
        check("R9", "bit_pos mid pattern", held, 5);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            bit_en = 1'b0;
            bit_in = 1'b1;
        end
        #1;
        check("R2", "bit_pos ignores disabled bits", int'(bit_pos), held);
        gap_mode = 1'b0;
    endtask

    task automatic t_832_acquire();
        do_reset(1'b1);
        lead_in();
        send_frame(1'b1);
        check("R3", "in_frame after one pattern", int'(in_frame), 0);
        send_frame(1'b1);
        check("R3", "in_frame after two patterns", int'(in_frame), 1);
        fs_cnt = 0;
        send_frame(1'b1);
        check("R8", "frame_start count 832", fs_cnt, 1);
        check("R8", "bit_pos at frame_start 832", fs_pos, 16);
    endtask

    task automatic t_832_fail();
        do_reset(1'b1);
        lead_in();
        send_frame(1'b1);
        send_frame(1'b0);
        check("R5", "832 no lock after miss", int'(in_frame), 0);
        send_frame(1'b1);
        check("R5", "832 restart first pattern", int'(in_frame), 0);
        send_frame(1'b1);
        check("R5", "832 lock after restart", int'(in_frame), 1);
    endtask

    task automatic t_832_loss();
        do_reset(1'b1);
        lead_in();
        repeat (2) send_frame(1'b1);
        repeat (3) send_frame(1'b0);
        check("R6", "832 still locked after three bad", int'(in_frame), 1);
        send_frame(1'b0);
        check("R6", "832 oof after fourth bad", int'(oof), 1);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_751_acquire();
        t_751_loss();
        t_751_confirm_fail();
        t_fmt_change();
        t_gaps();
        t_832_acquire();
        t_832_fail();
        t_832_loss();
        finish_up();
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not complete actual=1 expected=0");
        finish_up();
    end

endmodule